// File: doc/BRIEF.md
# Alternate Mark Inversion Encoder with Test Violation Insertion

This block turns a serial NRZ transmit stream into a pair of rail outputs using alternate mark inversion. Every accepted one is sent as a mark on one rail, and the rail used swaps from one mark to the next. Every accepted zero leaves both rails low. An input bit is accepted in any cycle where its valid strobe is high. The rails are registered, so the rails for an accepted bit appear in the clock cycle after it is presented.

For line testing, a host can request a single bipolar violation by raising a control bit. The raise arms the block. The block then watches the data that follows for a run of consecutive ones. On the last one of the run it sends a mark with the same polarity as the mark before it, instead of the opposite one. A done flag reports that the violation has gone out. Keeping the control bit high does not request another violation. The host must lower the bit and raise it again.

Top module: `ami_bpv_encoder`

## Requirements
- R1: After reset both rails and the done flag are low, and the first mark sent is on the positive rail.
- R2: An accepted one (valid high, data high) produces, in the next cycle, a mark on exactly one rail. The polarity is opposite to the previous mark, and any zeros or idle cycles between the two marks do not change this.
- R3: An accepted zero, or a cycle with valid low, leaves both rails low in the next cycle.
- R4: The positive and negative rails are never high in the same cycle.
- R5: A 0-to-1 change of the insert control, as seen at a clock edge, arms the block from the following cycle. Once armed, the block sends the third consecutive accepted one with the same polarity as the mark before it (RUN_LEN = 3).
- R6: The run count includes only ones accepted while the block is armed. Ones accepted before arming do not count. An accepted zero restarts the count. Cycles with valid low neither add to the count nor clear it.
- R7: Each arming inserts exactly one violation. After the violating mark, alternation resumes relative to that mark, and later runs of ones are sent as normal AMI.
- R8: Keeping the insert control high after a violation arms nothing more. A new violation needs the control to go low and then rise again.
- R9: The done flag goes high in the same cycle as the violating mark appears on a rail. It stays high until the next rising edge of the insert control, and it is low in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nrz_data | input | 1 | NRZ transmit bit |
| nrz_valid | input | 1 | Strobe that accepts nrz_data in this cycle |
| bpv_insert | input | 1 | Host control; a rising edge arms one violation |
| rail_pos | output | 1 | Positive rail mark |
| rail_neg | output | 1 | Negative rail mark |
| bpv_done | output | 1 | High from the violating mark until the next arming |

## Verification
The bound checker tests four properties on every cycle:
- the rails are never high together;
- an accepted one always yields a mark, and every other input yields idle rails;
- the done flag rises only together with a mark;
- the done flag clears after a request edge and otherwise holds.

Only the bench scenarios can show which polarity each mark takes. They also show where the violation lands relative to the arming and to any intervening zeros, that ones accepted before arming are ignored, and that a held request arms nothing more.

// File: rtl/ami_enc_pkg.sv
package ami_enc_pkg;

    typedef struct packed {
        logic req_prev;
        logic armed;
        logic done;
    } arm_state_t;

    typedef struct packed {
        logic pos;
        logic neg;
        logic last_pos;
    } mark_state_t;

endpackage

// File: rtl/ami_arm_ctrl.sv
module ami_arm_ctrl
    import ami_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic fire,
    output logic armed,
    output logic done
);

    arm_state_t st_d, st_q;
    logic       req_rise;

    always_comb begin
        st_d          = st_q;
        req_rise      = req & ~st_q.req_prev;
        st_d.req_prev = req;
        if (req_rise) begin
            st_d.armed = 1'b1;
            st_d.done  = 1'b0;
        end else if (fire) begin
            st_d.armed = 1'b0;
            st_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
    assign done  = st_q.done;

endmodule

// File: rtl/ami_run_cnt.sv
module ami_run_cnt #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic valid,
    input  logic data,
    output logic fire
);

    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = armed & valid & data & (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!armed || fire) begin
            cnt_d = '0;
        end else if (valid) begin
            cnt_d = data ? cnt_q + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ami_mark_gen.sv
module ami_mark_gen
    import ami_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic data,
    input  logic fire,
    output logic pos,
    output logic neg
);

    mark_state_t st_d, st_q;
    logic        mark;
    logic        use_pos;

    always_comb begin
        st_d     = st_q;
        mark     = valid & data;
        use_pos  = fire ? st_q.last_pos : ~st_q.last_pos;
        st_d.pos = mark & use_pos;
        st_d.neg = mark & ~use_pos;
        if (mark) begin
            st_d.last_pos = use_pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos = st_q.pos;
    assign neg = st_q.neg;

endmodule

// File: rtl/ami_bpv_encoder.sv
module ami_bpv_encoder #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_data,
    input  logic nrz_valid,
    input  logic bpv_insert,
    output logic rail_pos,
    output logic rail_neg,
    output logic bpv_done
);

    logic armed;
    logic fire;

    ami_arm_ctrl u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (bpv_insert),
        .fire  (fire),
        .armed (armed),
        .done  (bpv_done)
    );

    ami_run_cnt #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed),
        .valid (nrz_valid),
        .data  (nrz_data),
        .fire  (fire)
    );

    ami_mark_gen u_mark (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (nrz_valid),
        .data  (nrz_data),
        .fire  (fire),
        .pos   (rail_pos),
        .neg   (rail_neg)
    );

endmodule

// File: rtl/ami_bpv_encoder_chk.sv
module ami_bpv_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic nrz_data,
    input logic nrz_valid,
    input logic bpv_insert,
    input logic rail_pos,
    input logic rail_neg,
    input logic bpv_done
);

    AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rail_pos && rail_neg)); // R4

    AST_MARK_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (nrz_valid && nrz_data) |=> (rail_pos || rail_neg)); // R2

    AST_IDLE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(nrz_valid && nrz_data) |=> (!rail_pos && !rail_neg)); // R3

    AST_DONE_WITH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bpv_done) |-> (rail_pos || rail_neg)); // R9

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bpv_insert) |=> !bpv_done); // R9

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bpv_done && !$rose(bpv_insert)) |=> bpv_done); // R9

endmodule

bind ami_bpv_encoder ami_bpv_encoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nrz_data   (nrz_data),
    .nrz_valid  (nrz_valid),
    .bpv_insert (bpv_insert),
    .rail_pos   (rail_pos),
    .rail_neg   (rail_neg),
    .bpv_done   (bpv_done)
);

// File: tb/tb_ami_bpv_encoder.sv
module tb_ami_bpv_encoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nrz_data = 1'b0;
    logic nrz_valid = 1'b0;
    logic bpv_insert = 1'b0;
    logic rail_pos, rail_neg, bpv_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic exp_last_pos = 1'b0;

    always #5 clk = ~clk;

    ami_bpv_encoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .nrz_data   (nrz_data),
        .nrz_valid  (nrz_valid),
        .bpv_insert (bpv_insert),
        .rail_pos   (rail_pos),
        .rail_neg   (rail_neg),
        .bpv_done   (bpv_done)
    );

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic send(logic b, logic viol, string tag);
        logic ep;
        nrz_valid = 1'b1;
        nrz_data  = b;
        @(posedge clk);
        @(negedge clk);
        if (b) begin
            ep = viol ? exp_last_pos : ~exp_last_pos;
            exp_last_pos = ep;
            chk(tag, {rail_pos, rail_neg}, {ep, ~ep});
        end else begin
            chk(tag, {rail_pos, rail_neg}, 2'b00);
        end
        chk("R4", {1'b0, rail_pos & rail_neg}, 2'b00);
    endtask

    task automatic idle();
        nrz_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R3 idle", {rail_pos, rail_neg}, 2'b00);
    endtask

    task automatic arm();
        nrz_valid  = 1'b0;
        bpv_insert = 1'b0;
        @(posedge clk);
        @(negedge clk);
        bpv_insert = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 clear on arm", {1'b0, bpv_done}, 2'b00);
    endtask

    task automatic t_reset();
        chk("R1 reset rails", {rail_pos, rail_neg}, 2'b00);
        chk("R1 reset done", {1'b0, bpv_done}, 2'b00);
    endtask

    task automatic t_alternate();
        send(1, 0, "R1 first mark positive");
        send(1, 0, "R2 alternate");
        send(0, 0, "R3 zero");
        idle();
        send(1, 0, "R2 across zero");
        send(1, 0, "R2 alternate");
        send(1, 0, "R2 unarmed no violation");
    endtask

    task automatic t_basic();
        arm();
        send(1, 0, "R5 run1");
        send(1, 0, "R5 run2");
        send(1, 1, "R5 third one violates");
        chk("R9 done with violation", {1'b0, bpv_done}, 2'b01);
        send(1, 0, "R7 resume from violating mark");
        send(1, 0, "R7 single");
        send(1, 0, "R7 single");
        send(1, 0, "R7 no second violation");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 6; i++) send(1, 0, "R8 held high no rearm");
        chk("R9 done holds", {1'b0, bpv_done}, 2'b01);
    endtask

    task automatic t_zero_restart();
        arm();
        send(1, 0, "R6 run1");
        send(1, 0, "R6 run2");
        send(0, 0, "R6 zero restart");
        send(1, 0, "R6 after zero 1");
        idle();
        send(1, 0, "R6 idle keeps count");
        chk("R9 not done yet", {1'b0, bpv_done}, 2'b00);
        send(1, 1, "R6 violation after restart");
        chk("R9 done", {1'b0, bpv_done}, 2'b01);
    endtask

    task automatic t_pre_arm_ones();
        send(1, 0, "R6 pre-arm");
        send(1, 0, "R6 pre-arm");
        arm();
        send(1, 0, "R6 armed 1");
        send(1, 0, "R6 armed 2");
        send(1, 1, "R6 armed 3 violates");
        send(0, 0, "R3 zero");
        send(1, 0, "R7 alternation after violation");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alternate();
        t_basic();
        t_hold();
        t_zero_restart();
        t_pre_arm_ones();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule